// File: doc/BRIEF.md
# Frame Monitoring Rule Engine

This block decides what happens to a frame once its header has been parsed. A header descriptor arrives with a valid/ready handshake. It carries the ingress port, the egress port mask, the VLAN ID, the EtherType, the priority and both MAC addresses. The block compares the descriptor against a bank of programmable rules and returns one merged action for the frame. The merged action covers:
- discard,
- copy to the monitor path,
- steer to a chosen port,
- bump one or more statistics counters,
- replace the traffic class.

Each rule holds seven value/mask terms, one for each header field, and a two-bit combine mode. The combine mode turns the term results into a single hit. The modes are all-of, any-of, and the negation of each. Every rule also carries its own action word.

Software loads rules through a simple write port, one term value, term mask or control word per write. Headers stream in at one per cycle. The decision for each accepted header appears two cycles later. The matching stage copies the action words of all rules together with the hit vector, so a header is judged entirely by the rule set that was in force when it was accepted.

Top module: `frame_rule_engine`

## Requirements
- R1: A term takes part in a rule only when its mask is nonzero. A participating term matches when the header field equals the term value on every bit set in the mask.
- R2: The combine mode selects the rule's result from its participating terms: 0 is all match, 1 is any matches, 2 is not all, 3 is not any. With no participating terms, mode 0 gives true and mode 1 gives false.
- R3: A rule that is disabled, or that has not been written since reset, never matches. Reset disables every rule.
- R4: If any matching rule has its drop flag set, the decision drops the frame. A drop decision shows redirect low and redirect port 0.
- R5: When the frame is not dropped, redirect is set and the port comes from the lowest-numbered matching rule that has its redirect flag set.
- R6: A traffic class change comes from the lowest-numbered matching rule that has its change flag set, whether or not the frame is dropped. The change is shown as a valid flag plus a 4-bit class.
- R7: Mirror is the OR over all matching rules. The count vector has bit k set when any matching rule with its count flag set names counter k.
- R8: `in_ready` is high from the first cycle after reset. A header accepted at one clock edge yields `out_valid` with its decision after the second following edge. Headers may be accepted on consecutive edges. All decision outputs are 0 while `out_valid` is low.
- R9: A configuration write to rule r takes effect at its clock edge. Select values 2k and 2k+1 write the value and mask of term k, with k in this order: 0 source port, 1 destination mask, 2 VLAN, 3 EtherType, 4 priority, 5 source MAC, 6 destination MAC. Select 14 writes the control word:
  - bit 0: enable
  - bits 2:1: mode
  - bits 6:3: new class
  - bit 7: change flag
  - bits 11:8: counter index
  - bit 12: count flag
  - bits 17:13: redirect port
  - bit 18: redirect flag
  - bit 19: mirror flag
  - bit 20: drop flag

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rule | input | 4 | Rule being written |
| cfg_sel | input | 4 | Term value, term mask or control select |
| cfg_data | input | 48 | Write data, right aligned |
| in_valid | input | 1 | Header descriptor valid |
| in_ready | output | 1 | Header can be accepted |
| in_src_port | input | 5 | Ingress port number |
| in_dst_mask | input | 24 | Egress port mask |
| in_vlan | input | 12 | VLAN ID |
| in_type | input | 16 | EtherType |
| in_prio | input | 3 | Frame priority |
| in_smac | input | 48 | Source MAC address |
| in_dmac | input | 48 | Destination MAC address |
| out_valid | output | 1 | Decision valid |
| out_drop | output | 1 | Discard the frame |
| out_mirror | output | 1 | Copy to the monitor path |
| out_redirect | output | 1 | Steer to out_redir_port |
| out_redir_port | output | 5 | Redirect target |
| out_count_vec | output | 16 | Counters to increment |
| out_prio_valid | output | 1 | Traffic class replaced |
| out_prio_tc | output | 4 | New traffic class |

## Verification
The hardest situation to reach is a single header hit by several rules at once, where those rules carry conflicting actions. That means drop alongside redirect, two redirect ports, or two new classes, and it has to happen while headers stream back to back.

The stimulus programs overlapping rules:
- two rules on the same VLAN with different ports and classes,
- a drop rule that shares a field with an any-of rule,
- a not-any rule that hits whenever a destination bit is clear.

It then feeds a table of headers on consecutive cycles, each header chosen to hit a known subset of those rules. Afterwards, directed writes flip individual rules between headers. These cover disabling the winning rule, enabling a stored but disabled rule, and adding a rule with no terms. The bench then checks that the precedence and reset behaviour follow the new rule set.

// File: rtl/fre_pkg.sv
package fre_pkg;
  localparam int PORT_W = 5;
  localparam int NPORTS = 24;
  localparam int VLAN_W = 12;
  localparam int TYPE_W = 16;
  localparam int PRIO_W = 3;
  localparam int MAC_W  = 48;
  localparam int TC_W   = 4;
  localparam int CIDX_W = 4;
  localparam int NCNT   = 1 << CIDX_W;
  localparam int NTERMS = 7;
  localparam int DATA_W = MAC_W;
  localparam int SEL_W  = 4;
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(2 * NTERMS);

  typedef enum logic [1:0] {
    CMB_ALL  = 2'd0,
    CMB_ANY  = 2'd1,
    CMB_NALL = 2'd2,
    CMB_NANY = 2'd3
  } cmb_t;

  typedef struct packed {
    logic [PORT_W-1:0] src;
    logic [NPORTS-1:0] dst;
    logic [VLAN_W-1:0] vlan;
    logic [TYPE_W-1:0] etype;
    logic [PRIO_W-1:0] prio;
    logic [MAC_W-1:0]  smac;
    logic [MAC_W-1:0]  dmac;
  } hdr_t;

  typedef struct packed {
    logic              drop;
    logic              mirror;
    logic              redir;
    logic [PORT_W-1:0] port;
    logic              count;
    logic [CIDX_W-1:0] cidx;
    logic              prio_chg;
    logic [TC_W-1:0]   tc;
  } act_t;

  localparam int ACT_W = $bits(act_t);
  localparam int ACT_LSB = 3;

  typedef struct packed {
    logic              drop;
    logic              mirror;
    logic              redir;
    logic [PORT_W-1:0] port;
    logic [NCNT-1:0]   cvec;
    logic              pv;
    logic [TC_W-1:0]   tc;
  } dec_t;

  // Header field k, zero extended to the term width.
  function automatic logic [DATA_W-1:0] field_of(hdr_t h, int k);
    logic [DATA_W-1:0] f;
    f = '0;
    case (k)
      0: f[PORT_W-1:0] = h.src;
      1: f[NPORTS-1:0] = h.dst;
      2: f[VLAN_W-1:0] = h.vlan;
      3: f[TYPE_W-1:0] = h.etype;
      4: f[PRIO_W-1:0] = h.prio;
      5: f = h.smac;
      default: f = h.dmac;
    endcase
    return f;
  endfunction

  function automatic logic term_used(logic [DATA_W-1:0] msk);
    return |msk;
  endfunction

  function automatic logic term_ok(logic [DATA_W-1:0] f, logic [DATA_W-1:0] v,
                                   logic [DATA_W-1:0] msk);
    return ((f ^ v) & msk) == '0;
  endfunction

  function automatic logic combine(cmb_t mode, logic [NTERMS-1:0] used,
                                   logic [NTERMS-1:0] ok);
    logic all_r, any_r;
    all_r = &(ok | ~used);
    any_r = |(ok & used);
    case (mode)
      CMB_ALL:  return all_r;
      CMB_ANY:  return any_r;
      CMB_NALL: return !all_r;
      default:  return !any_r;
    endcase
  endfunction
endpackage

// File: rtl/fre_rule_bank.sv
module fre_rule_bank
  import fre_pkg::*;
#(
  parameter int NUM_RULES = 16,
  parameter int RULE_W = $clog2(NUM_RULES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [RULE_W-1:0] cfg_rule,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  output logic [NUM_RULES-1:0] rule_en,
  output cmb_t              rule_mode [NUM_RULES],
  output act_t              rule_act  [NUM_RULES],
  output logic [DATA_W-1:0] rule_val  [NUM_RULES][NTERMS],
  output logic [DATA_W-1:0] rule_msk  [NUM_RULES][NTERMS]
);
  logic [SEL_W-2:0] w_term;
  logic             w_is_msk;
  logic             w_hit_rule;
  logic             w_ctrl_wr;
  logic             w_term_wr;

  assign w_term     = cfg_sel[SEL_W-1:1];
  assign w_is_msk   = cfg_sel[0];
  assign w_hit_rule = cfg_we && (int'(cfg_rule) < NUM_RULES);
  assign w_ctrl_wr  = w_hit_rule && (cfg_sel == SEL_CTRL);
  assign w_term_wr  = w_hit_rule && (cfg_sel < SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      rule_en <= '0;
      for (int r = 0; r < NUM_RULES; r++) begin
        rule_mode[r] <= CMB_ALL;
        rule_act[r]  <= '0;
        for (int t = 0; t < NTERMS; t++) begin
          rule_val[r][t] <= '0;
          rule_msk[r][t] <= '0;
        end
      end
    end else if (w_ctrl_wr) begin
      rule_en[cfg_rule]   <= cfg_data[0];
      rule_mode[cfg_rule] <= cmb_t'(cfg_data[2:1]);
      rule_act[cfg_rule]  <= act_t'(cfg_data[ACT_LSB +: ACT_W]);
    end else if (w_term_wr) begin
      if (w_is_msk) rule_msk[cfg_rule][w_term] <= cfg_data;
      else          rule_val[cfg_rule][w_term] <= cfg_data;
    end
  end

  // R9: the enable bit of a control write is visible after its edge
  a_r9_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    w_ctrl_wr |=> rule_en[$past(cfg_rule)] == $past(cfg_data[0]));

  // R3: every rule leaves reset disabled
  a_r3_reset_off: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> rule_en == '0);
endmodule

// File: rtl/fre_rule_match.sv
module fre_rule_match
  import fre_pkg::*;
(
  input  hdr_t              hdr,
  input  logic              en,
  input  cmb_t              mode,
  input  logic [DATA_W-1:0] val [NTERMS],
  input  logic [DATA_W-1:0] msk [NTERMS],
  output logic              hit
);
  logic [NTERMS-1:0] used;
  logic [NTERMS-1:0] ok;

  for (genvar t = 0; t < NTERMS; t++) begin : g_term
    assign used[t] = term_used(msk[t]);
    assign ok[t]   = term_ok(field_of(hdr, t), val[t], msk[t]);
  end

  assign hit = en & combine(mode, used, ok);
endmodule

// File: rtl/fre_merge.sv
module fre_merge
  import fre_pkg::*;
#(
  parameter int NUM_RULES = 16
) (
  input  logic [NUM_RULES-1:0] hits,
  input  act_t                 acts [NUM_RULES],
  output dec_t                 dec
);
  // Walk from the highest rule down so the lowest-numbered hit is written last.
  always_comb begin
    dec = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hits[i]) begin
        if (acts[i].drop)   dec.drop = 1'b1;
        if (acts[i].mirror) dec.mirror = 1'b1;
        if (acts[i].count)  dec.cvec[acts[i].cidx] = 1'b1;
        if (acts[i].redir) begin
          dec.redir = 1'b1;
          dec.port  = acts[i].port;
        end
        if (acts[i].prio_chg) begin
          dec.pv = 1'b1;
          dec.tc = acts[i].tc;
        end
      end
    end
    if (dec.drop) begin
      dec.redir = 1'b0;
      dec.port  = '0;
    end
  end
endmodule

// File: rtl/frame_rule_engine.sv
module frame_rule_engine
  import fre_pkg::*;
#(
  parameter int NUM_RULES = 16,
  parameter int RULE_W = $clog2(NUM_RULES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [RULE_W-1:0] cfg_rule,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PORT_W-1:0] in_src_port,
  input  logic [NPORTS-1:0] in_dst_mask,
  input  logic [VLAN_W-1:0] in_vlan,
  input  logic [TYPE_W-1:0] in_type,
  input  logic [PRIO_W-1:0] in_prio,
  input  logic [MAC_W-1:0]  in_smac,
  input  logic [MAC_W-1:0]  in_dmac,
  output logic              out_valid,
  output logic              out_drop,
  output logic              out_mirror,
  output logic              out_redirect,
  output logic [PORT_W-1:0] out_redir_port,
  output logic [NCNT-1:0]   out_count_vec,
  output logic              out_prio_valid,
  output logic [TC_W-1:0]   out_prio_tc
);
  hdr_t                 hdr;
  logic                 ready_q;
  logic                 accept;
  logic [NUM_RULES-1:0] rule_en;
  cmb_t                 rule_mode [NUM_RULES];
  act_t                 rule_act  [NUM_RULES];
  logic [DATA_W-1:0]    rule_val  [NUM_RULES][NTERMS];
  logic [DATA_W-1:0]    rule_msk  [NUM_RULES][NTERMS];
  logic [NUM_RULES-1:0] hits;
  logic                 s1_valid;
  logic [NUM_RULES-1:0] s1_hits;
  act_t                 s1_acts [NUM_RULES];
  dec_t                 merged;
  dec_t                 s2_dec;
  logic                 s2_valid;

  assign hdr = '{src: in_src_port, dst: in_dst_mask, vlan: in_vlan, etype: in_type,
                 prio: in_prio, smac: in_smac, dmac: in_dmac};
  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  fre_rule_bank #(.NUM_RULES(NUM_RULES), .RULE_W(RULE_W)) i_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_rule(cfg_rule), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .rule_en(rule_en), .rule_mode(rule_mode),
    .rule_act(rule_act), .rule_val(rule_val), .rule_msk(rule_msk)
  );

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    fre_rule_match i_match (
      .hdr(hdr), .en(rule_en[r]), .mode(rule_mode[r]),
      .val(rule_val[r]), .msk(rule_msk[r]), .hit(hits[r])
    );
  end

  // Stage 1: hit vector plus a snapshot of every rule's action word.
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q  <= 1'b0;
      s1_valid <= 1'b0;
      s1_hits  <= '0;
      for (int r = 0; r < NUM_RULES; r++) s1_acts[r] <= '0;
    end else begin
      ready_q  <= 1'b1;
      s1_valid <= accept;
      s1_hits  <= accept ? hits : '0;
      if (accept)
        for (int r = 0; r < NUM_RULES; r++) s1_acts[r] <= rule_act[r];
    end
  end

  fre_merge #(.NUM_RULES(NUM_RULES)) i_merge (
    .hits(s1_hits), .acts(s1_acts), .dec(merged)
  );

  // Stage 2: merged decision.
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_dec   <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_dec   <= s1_valid ? merged : '0;
    end
  end

  assign out_valid      = s2_valid;
  assign out_drop       = s2_dec.drop;
  assign out_mirror     = s2_dec.mirror;
  assign out_redirect   = s2_dec.redir;
  assign out_redir_port = s2_dec.port;
  assign out_count_vec  = s2_dec.cvec;
  assign out_prio_valid = s2_dec.pv;
  assign out_prio_tc    = s2_dec.tc;

  // R8: an accepted header gives a decision two edges later
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##2 out_valid);

  // R8: decision outputs stay zero while no decision is shown
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_drop && !out_mirror && !out_redirect && out_redir_port == '0
                   && out_count_vec == '0 && !out_prio_valid && out_prio_tc == '0);

  // R4: a dropped frame is never steered
  a_r4_drop_excl: assert property (@(posedge clk) disable iff (rst)
    out_drop |-> !out_redirect && out_redir_port == '0);

  // R7: each set counter bit needs at least one hitting rule
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_count_vec) <= $countones($past(s1_hits)));

  // R3: nothing can match without an enabled rule
  a_r3_no_rule_no_hit: assert property (@(posedge clk) disable iff (rst)
    rule_en == '0 |-> hits == '0);
endmodule

// File: tb/test_frame_rule_engine.sv
module test_frame_rule_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_rule = '0;
  logic [3:0]  cfg_sel = '0;
  logic [47:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_src_port = '0;
  logic [23:0] in_dst_mask = '0;
  logic [11:0] in_vlan = '0;
  logic [15:0] in_type = '0;
  logic [2:0]  in_prio = '0;
  logic [47:0] in_smac = '0;
  logic [47:0] in_dmac = '0;
  logic        out_valid, out_drop, out_mirror, out_redirect, out_prio_valid;
  logic [4:0]  out_redir_port;
  logic [15:0] out_count_vec;
  logic [3:0]  out_prio_tc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  frame_rule_engine i_frame_rule_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_rule(cfg_rule), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_port(in_src_port), .in_dst_mask(in_dst_mask), .in_vlan(in_vlan),
    .in_type(in_type), .in_prio(in_prio), .in_smac(in_smac), .in_dmac(in_dmac),
    .out_valid(out_valid), .out_drop(out_drop), .out_mirror(out_mirror),
    .out_redirect(out_redirect), .out_redir_port(out_redir_port),
    .out_count_vec(out_count_vec), .out_prio_valid(out_prio_valid),
    .out_prio_tc(out_prio_tc)
  );

  // Expected word: {drop, mirror, redirect, port[4:0], count[15:0], class valid, class[3:0]}
  typedef struct packed {
    logic [4:0]  sp;
    logic [23:0] dp;
    logic [11:0] vl;
    logic [15:0] ty;
    logic [2:0]  pr;
    logic [47:0] sm;
    logic [47:0] dm;
    logic [28:0] ex;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{5'd1, 24'h1, 12'd5,   16'h86DD, 3'd0, 48'h0, 48'h0,
      {1'b0, 1'b0, 1'b0, 5'd0, 16'h0000, 1'b0, 4'd0}},
    '{5'd1, 24'h1, 12'd100, 16'h86DD, 3'd0, 48'h0, 48'h0,
      {1'b0, 1'b0, 1'b1, 5'd7, 16'h0000, 1'b1, 4'd5}},
    '{5'd3, 24'h1, 12'd5,   16'h86DD, 3'd0, 48'h0, 48'h0,
      {1'b0, 1'b1, 1'b0, 5'd0, 16'h0004, 1'b0, 4'd0}},
    '{5'd1, 24'h1, 12'd5,   16'h86DD, 3'd0, 48'h0, 48'h112233445566,
      {1'b0, 1'b1, 1'b0, 5'd0, 16'h0004, 1'b0, 4'd0}},
    '{5'd1, 24'h1, 12'd100, 16'h0800, 3'd5, 48'h0, 48'h0,
      {1'b1, 1'b0, 1'b0, 5'd0, 16'h0200, 1'b1, 4'd5}},
    '{5'd3, 24'h2, 12'd5,   16'h0800, 3'd5, 48'h0, 48'h0,
      {1'b1, 1'b1, 1'b0, 5'd0, 16'h8204, 1'b0, 4'd0}},
    '{5'd1, 24'h1, 12'd5,   16'h86DD, 3'd0, 48'h11AB, 48'h0,
      {1'b0, 1'b0, 1'b0, 5'd0, 16'h0000, 1'b1, 4'd3}},
    '{5'd1, 24'h1, 12'd100, 16'h86DD, 3'd0, 48'h11AB, 48'h0,
      {1'b0, 1'b0, 1'b1, 5'd7, 16'h0000, 1'b1, 4'd5}},
    '{5'd1, 24'h1, 12'd5,   16'h0800, 3'd4, 48'h0, 48'h0,
      {1'b0, 1'b0, 1'b0, 5'd0, 16'h0000, 1'b0, 4'd0}},
    '{5'd1, 24'h1, 12'd5,   16'h86DD, 3'd0, 48'hDEADBEEF0001, 48'h0,
      {1'b0, 1'b0, 1'b0, 5'd0, 16'h0000, 1'b0, 4'd0}}
  };

  // Control word layout as stated in R9.
  function automatic logic [47:0] ctl(bit en, bit [1:0] mode, bit drop, bit mir,
                                      bit rd, bit [4:0] port, bit cnt, bit [3:0] cidx,
                                      bit pc, bit [3:0] tc);
    return {27'b0, drop, mir, rd, port, cnt, cidx, pc, tc, mode, en};
  endfunction

  task automatic wr(input int rule, input int sel, input logic [47:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rule = 4'(rule); cfg_sel = 4'(sel); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1'b1; in_src_port = v.sp; in_dst_mask = v.dp; in_vlan = v.vl;
    in_type = v.ty; in_prio = v.pr; in_smac = v.sm; in_dmac = v.dm;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [28:0] got_dec();
    return {out_drop, out_mirror, out_redirect, out_redir_port, out_count_vec,
            out_prio_valid, out_prio_tc};
  endfunction

  // Drive one header, then check its decision two negedges later.
  task automatic one(input string tag, input vec_t v, input logic [28:0] exp);
    @(negedge clk);
    drive(v);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    chk(tag, {3'b0, got_dec()}, {3'b0, exp});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 ready low in reset", {31'b0, in_ready}, 32'd0);
    chk("R8 reset out_valid", {31'b0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 ready after reset", {31'b0, in_ready}, 32'd1);
    chk("R8 reset decision zero", {3'b0, got_dec()}, 32'd0);

    // Rule 0: VLAN 100, all-of -> redirect 7, class 5
    wr(0, 4, 48'd100); wr(0, 5, 48'hFFF);
    wr(0, 14, ctl(1, 0, 0, 0, 1, 5'd7, 0, 4'd0, 1, 4'd5));
    // Rule 1: source port 3 or dest MAC -> mirror, counter 2
    wr(1, 0, 48'd3); wr(1, 1, 48'h1F);
    wr(1, 12, 48'h112233445566); wr(1, 13, 48'hFFFFFFFFFFFF);
    wr(1, 14, ctl(1, 1, 0, 1, 0, 5'd0, 1, 4'd2, 0, 4'd0));
    // Rule 2: IPv4 and priority 5 -> drop, counter 9
    wr(2, 6, 48'h0800); wr(2, 7, 48'hFFFF); wr(2, 8, 48'd5); wr(2, 9, 48'h7);
    wr(2, 14, ctl(1, 0, 1, 0, 0, 5'd0, 1, 4'd9, 0, 4'd0));
    // Rule 3: not-any on dest bit 0 -> counter 15
    wr(3, 2, 48'h1); wr(3, 3, 48'h1);
    wr(3, 14, ctl(1, 3, 0, 0, 0, 5'd0, 1, 4'd15, 0, 4'd0));
    // Rule 4: terms stored but disabled -> drop
    wr(4, 10, 48'hDEADBEEF0001); wr(4, 11, 48'hFFFFFFFFFFFF);
    wr(4, 14, ctl(0, 0, 1, 0, 0, 5'd0, 0, 4'd0, 0, 4'd0));
    // Rule 5: enabled, no terms, any-of -> never hits
    wr(5, 14, ctl(1, 1, 1, 0, 0, 5'd0, 0, 4'd0, 0, 4'd0));
    // Rule 6: VLAN 100 -> redirect 20, class 9 (loses to rule 0)
    wr(6, 4, 48'd100); wr(6, 5, 48'hFFF);
    wr(6, 14, ctl(1, 0, 0, 0, 1, 5'd20, 0, 4'd0, 1, 4'd9));
    // Rule 7: low byte of source MAC is AB -> class 3
    wr(7, 10, 48'hAB); wr(7, 11, 48'hFF);
    wr(7, 14, ctl(1, 0, 0, 0, 0, 5'd0, 0, 4'd0, 1, 4'd3));

    // Table walk, one header per cycle (R1 R2 R4 R5 R6 R7 R8)
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk($sformatf("R8 vec%0d valid", i - 2), {31'b0, out_valid}, 32'd1);
        chk($sformatf("R1 R2 R4 R5 R6 R7 vec%0d", i - 2), {3'b0, got_dec()},
            {3'b0, VECS[i-2].ex});
      end
      if (i < NV) drive(VECS[i]);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R8 idle no valid", {31'b0, out_valid}, 32'd0);
    chk("R8 idle zero", {3'b0, got_dec()}, 32'd0);

    // R5 R6: disable rule 0, rule 6 becomes the lowest hit
    wr(0, 14, ctl(0, 0, 0, 0, 1, 5'd7, 0, 4'd0, 1, 4'd5));
    one("R5 R6 fallback", VECS[1], {1'b0, 1'b0, 1'b1, 5'd20, 16'h0, 1'b1, 4'd9});
    // R9: enable stored rule 4
    wr(4, 14, ctl(1, 0, 1, 0, 0, 5'd0, 0, 4'd0, 0, 4'd0));
    one("R9 enable", VECS[9], {1'b1, 1'b0, 1'b0, 5'd0, 16'h0, 1'b0, 4'd0});
    // R2: all-of with no terms always hits
    wr(9, 14, ctl(1, 0, 0, 0, 0, 5'd0, 1, 4'd1, 0, 4'd0));
    one("R2 empty all-of", VECS[0], {1'b0, 1'b0, 1'b0, 5'd0, 16'h0002, 1'b0, 4'd0});

    // R3: reset wipes the rules
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R3 reset valid", {31'b0, out_valid}, 32'd0);
    one("R3 after reset", VECS[1], 29'd0);
    one("R3 after reset drop", VECS[4], 29'd0);

    done = 1'b1;
    summary();
  end
endmodule